// File: doc/BRIEF.md
# Edge-Triggered Set-Reset Phase Detector

This block is a sampled-logic phase detector for a clock-recovery or frequency-synthesis loop. It watches two single-bit inputs: a reference signal and a feedback signal coming back from the loop's oscillator. A single state flag is set by each rising edge of the reference and cleared by each rising edge of the feedback. Only rising transitions matter, so the duty cycle of either input has no effect. Averaged over time, the flag's duty is proportional to the phase lag of the feedback behind the reference. That lag can range over a full cycle, 0 to 360 degrees. At 180 degrees, the loop's centre point, the duty is 50 percent.

Both inputs are asynchronous to the fast system clock. Each one passes through its own synchroniser chain and then a rising-edge detector. The flag is available directly for an external filter. The block also measures the high time itself: a counter adds up the system clocks during which the flag was high in each reference period. The total is presented on every reference edge together with a one-cycle valid strobe. When the reference has no edges, the flag stays cleared, which pushes the loop's oscillator toward its lowest frequency.

Top module: `edge_phase_flag`

## Requirements
- R1: While `rst` is high at a clock edge, `flag_o`, `cnt_valid_o` and `high_cnt_o` are all 0 after that edge.
- R2: A rising edge on `ref_in` with no feedback edge detected in the same cycle sets `flag_o`. `ref_in` is sampled by SYNC_STAGES flops and then edge-detected, so `flag_o` goes high on the (SYNC_STAGES+1)-th rising clock edge after the first edge that samples `ref_in` high (the third edge with the default of 2).
- R3: A rising edge on `fb_in` clears `flag_o`, with the same latency as R2.
- R4: When rising edges of both inputs are detected in the same clock cycle, clear wins and `flag_o` is 0 afterwards.
- R5: Input levels and falling edges have no effect. `flag_o` changes only in response to a detected rising edge, and a held-high input produces only one edge.
- R6: On the same clock edge where a reference rising edge sets the flag, `high_cnt_o` is loaded with the number of clock cycles in which `flag_o` was high since the previous reference edge (or since reset). `cnt_valid_o` is high for exactly that one following cycle, and `high_cnt_o` does not change at any other time.
- R7: The high-time count saturates at 2^CNT_W-1 instead of wrapping.
- R8: With no reference edges, `flag_o` stays 0 whatever the feedback does, and `cnt_valid_o` stays 0.
- R9: With the feedback rising half a reference period after the reference, the reported count is half the period (50 percent duty).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than either input |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference signal, asynchronous; its rising edges set the flag |
| fb_in | input | 1 | Feedback signal, asynchronous; its rising edges clear the flag |
| flag_o | output | 1 | Phase flag; its average duty encodes the phase difference |
| cnt_valid_o | output | 1 | One-cycle strobe that marks a new high-time count |
| high_cnt_o | output | CNT_W | Clock cycles the flag was high in the last reference period |

## Verification
A flag that is stuck or mis-prioritised shows at `flag_o` SYNC_STAGES+1 edges after the offending input edge. The bench therefore compares the flag on every cycle against a model of the input edges that is delayed by exactly that amount. A bad accumulator shows at the next reference edge, at the latest one reference period later, as a wrong `high_cnt_o` value popped from the scoreboard. A lost or extra strobe shows the same way, as an empty or non-empty queue. Long periods with no feedback edge check the saturation, and feedback-only stretches check that no count is reported.

// File: rtl/epf_pkg.sv
package epf_pkg;

    // Channel indices into the synchroniser array
    localparam int unsigned NUM_CH = 2;
    localparam int unsigned CH_REF = 0;
    localparam int unsigned CH_FB  = 1;

    // Edge events presented to the flag register for one cycle
    typedef struct packed {
        logic set_ev;
        logic clr_ev;
    } flag_req_t;

    typedef enum logic [1:0] {
        FLAG_HOLD  = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_CLEAR = 2'd2
    } flag_cmd_e;

    // Clear has priority over set
    function automatic flag_cmd_e pick_cmd(input flag_req_t req);
        if (req.clr_ev) begin
            return FLAG_CLEAR;
        end
        if (req.set_ev) begin
            return FLAG_SET;
        end
        return FLAG_HOLD;
    endfunction

    function automatic logic apply_cmd(input flag_cmd_e cmd, input logic cur);
        case (cmd)
            FLAG_SET:   return 1'b1;
            FLAG_CLEAR: return 1'b0;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/epf_edge_sync.sv
module epf_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= din;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], din};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/epf_flag_core.sv
module epf_flag_core
    import epf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_req_t req,
    output logic      flag_q
);

    flag_cmd_e cmd;
    logic      flag_d;

    always_comb begin
        cmd    = pick_cmd(req);
        flag_d = apply_cmd(cmd, flag_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

endmodule

// File: rtl/epf_high_meter.sv
module epf_high_meter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flag,
    input  logic             latch_ev,
    output logic [CNT_W-1:0] cnt_o,
    output logic             valid_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] acc_q;
    logic [CNT_W-1:0] acc_inc;

    // The current cycle's flag counts toward the period that is closing
    always_comb begin
        if (flag && (acc_q != CNT_MAX)) begin
            acc_inc = acc_q + CNT_ONE;
        end else begin
            acc_inc = acc_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            cnt_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= latch_ev;
            if (latch_ev) begin
                cnt_o <= acc_inc;
                acc_q <= '0;
            end else begin
                acc_q <= acc_inc;
            end
        end
    end

endmodule

// File: rtl/edge_phase_flag.sv
module edge_phase_flag
    import epf_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             fb_in,
    output logic             flag_o,
    output logic             cnt_valid_o,
    output logic [CNT_W-1:0] high_cnt_o
);

    logic [NUM_CH-1:0] raw_vec;
    logic [NUM_CH-1:0] rise_vec;
    logic              ref_rise;
    logic              fb_rise;
    flag_req_t         req;

    assign raw_vec[CH_REF] = ref_in;
    assign raw_vec[CH_FB]  = fb_in;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_in
            epf_edge_sync #(
                .STAGES (SYNC_STAGES)
            ) u_sync (
                .clk    (clk),
                .rst    (rst),
                .din    (raw_vec[ch]),
                .rise_o (rise_vec[ch])
            );
        end
    endgenerate

    assign ref_rise   = rise_vec[CH_REF];
    assign fb_rise    = rise_vec[CH_FB];
    assign req.set_ev = ref_rise;
    assign req.clr_ev = fb_rise;

    epf_flag_core u_flag (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .flag_q (flag_o)
    );

    epf_high_meter #(
        .CNT_W (CNT_W)
    ) u_meter (
        .clk      (clk),
        .rst      (rst),
        .flag     (flag_o),
        .latch_ev (ref_rise),
        .cnt_o    (high_cnt_o),
        .valid_o  (cnt_valid_o)
    );

endmodule

// File: rtl/epf_checker.sv
module epf_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_rise,
    input logic             fb_rise,
    input logic             flag_o,
    input logic             cnt_valid_o,
    input logic [CNT_W-1:0] high_cnt_o
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!flag_o && !cnt_valid_o && (high_cnt_o == '0)));

    a_r2_ref_sets: assert property (@(posedge clk) disable iff (rst)
        (ref_rise && !fb_rise) |=> flag_o);

    a_r3_fb_clears: assert property (@(posedge clk) disable iff (rst)
        (fb_rise && !ref_rise) |=> !flag_o);

    a_r4_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (ref_rise && fb_rise) |=> !flag_o);

    a_r5_hold_without_edge: assert property (@(posedge clk) disable iff (rst)
        (!ref_rise && !fb_rise) |=> $stable(flag_o));

    a_r5_single_edge: assert property (@(posedge clk) disable iff (rst)
        ref_rise |=> !ref_rise);

    a_r6_strobe_follows_ref: assert property (@(posedge clk) disable iff (rst)
        ref_rise |=> cnt_valid_o);

    a_r6_no_strobe_otherwise: assert property (@(posedge clk) disable iff (rst)
        !ref_rise |=> !cnt_valid_o);

    a_r6_count_held: assert property (@(posedge clk) disable iff (rst)
        !cnt_valid_o |-> $stable(high_cnt_o));

endmodule

bind edge_phase_flag epf_checker #(
    .CNT_W (CNT_W)
) u_epf_checker (
    .clk         (clk),
    .rst         (rst),
    .ref_rise    (ref_rise),
    .fb_rise     (fb_rise),
    .flag_o      (flag_o),
    .cnt_valid_o (cnt_valid_o),
    .high_cnt_o  (high_cnt_o)
);

// File: tb/test_edge_phase_flag.sv
`timescale 1ns/1ps
module test_edge_phase_flag;

    localparam int unsigned CNT_W   = 8;
    localparam int          CNT_MAX = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ref_in = 1'b0;
    logic             fb_in = 1'b0;
    logic             flag_o;
    logic             cnt_valid_o;
    logic [CNT_W-1:0] high_cnt_o;

    int checks = 0;
    int fails  = 0;
    int valids_seen = 0;
    int pushes = 0;
    bit done = 1'b0;

    int exp_q[$];

    // Requirement-level model, advanced once per driven cycle
    logic m_flag = 1'b0;
    int   m_acc  = 0;
    logic prev_r = 1'b0;
    logic prev_f = 1'b0;
    logic hist[0:2] = '{1'b0, 1'b0, 1'b0};
    int   htag[0:2] = '{5, 5, 5};
    logic last_valid = 1'b0;

    always #4 clk = ~clk;

    edge_phase_flag #(
        .SYNC_STAGES (2),
        .CNT_W       (CNT_W)
    ) i_edge_phase_flag (
        .clk         (clk),
        .rst         (rst),
        .ref_in      (ref_in),
        .fb_in       (fb_in),
        .flag_o      (flag_o),
        .cnt_valid_o (cnt_valid_o),
        .high_cnt_o  (high_cnt_o)
    );

    function automatic string tag_name(input int t);
        case (t)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            8: return "R8";
            default: return "R5";
        endcase
    endfunction

    // Driver: compares the flag with the model three cycles back, then drives
    task automatic tick(input logic r, input logic f);
        bit rr;
        bit fr;
        @(negedge clk);
        checks++;
        if (flag_o !== hist[2]) begin
            fails++;
            $display("FAIL %s flag_o actual=%b expected=%b at %0t",
                     tag_name(htag[2]), flag_o, hist[2], $time);
        end
        ref_in = r;
        fb_in  = f;
        rr = r && !prev_r;
        fr = f && !prev_f;
        prev_r = r;
        prev_f = f;
        if (rr) begin
            exp_q.push_back(m_acc);
            pushes++;
            m_acc = 0;
        end
        hist[2] = hist[1];
        htag[2] = htag[1];
        hist[1] = hist[0];
        htag[1] = htag[0];
        if (fr) begin
            m_flag = 1'b0;
        end else if (rr) begin
            m_flag = 1'b1;
        end
        if (m_flag && m_acc < CNT_MAX) begin
            m_acc++;
        end
        hist[0] = m_flag;
        htag[0] = (rr && fr) ? 4 : fr ? 3 : rr ? 2 : 5;
    endtask

    // One reference period: ref high for rw cycles, fb high for fw cycles from d
    task automatic period(input int p, input int d, input int rw, input int fw,
                          input bit fb_on);
        for (int i = 0; i < p; i++) begin
            tick(i < rw, fb_on && (i >= d) && (i < d + fw));
        end
    endtask

    // Monitor: pops the expected count on every strobe
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (cnt_valid_o) begin
                valids_seen++;
                checks++;
                if (last_valid) begin
                    fails++;
                    $display("FAIL R6 strobe longer than one cycle actual=1 expected=0");
                end
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R6 unexpected strobe actual=%0d expected=none",
                             high_cnt_o);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (int'(high_cnt_o) != e) begin
                        fails++;
                        $display("FAIL R6/R7 high_cnt_o actual=%0d expected=%0d",
                                 high_cnt_o, e);
                    end
                end
            end
            last_valid = cnt_valid_o;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state right after reset
        checks++;
        if (flag_o !== 1'b0 || cnt_valid_o !== 1'b0 || high_cnt_o !== '0) begin
            fails++;
            $display("FAIL R1 reset outputs actual=%b%b%0d expected=000",
                     flag_o, cnt_valid_o, high_cnt_o);
        end

        // R8: feedback activity only, no reference edges
        for (int k = 0; k < 4; k++) begin
            tick(1'b0, 1'b1);
            tick(1'b0, 1'b0);
            tick(1'b0, 1'b0);
        end
        for (int k = 0; k < 4; k++) tick(1'b0, 1'b0);
        checks++;
        if (valids_seen != 0 || flag_o !== 1'b0) begin
            fails++;
            $display("FAIL R8 no reference actual=%0d/%b expected=0/0",
                     valids_seen, flag_o);
        end

        // R9: 180 degrees, count half the period
        for (int k = 0; k < 3; k++) period(8, 4, 4, 4, 1'b1);
        // R2 R3: various lags and duty cycles
        period(10, 2, 1, 1, 1'b1);
        period(10, 7, 9, 2, 1'b1);
        period(12, 5, 5, 6, 1'b1);
        // R4: simultaneous edges
        period(6, 0, 3, 1, 1'b1);
        period(6, 0, 1, 3, 1'b1);
        // R5: reference held high while feedback toggles
        period(20, 3, 18, 1, 1'b1);
        period(20, 1, 2, 17, 1'b1);
        // No feedback: full period counted
        period(9, 3, 2, 1, 1'b0);
        period(9, 3, 2, 1, 1'b0);
        // R7: saturation boundary
        period(300, 254, 10, 2, 1'b1);
        period(300, 255, 10, 2, 1'b1);
        period(300, 270, 10, 2, 1'b1);
        period(300, 0, 150, 1, 1'b0);
        period(8, 4, 4, 4, 1'b1);
        // Flush the last period
        tick(1'b1, 1'b0);
        for (int k = 0; k < 8; k++) tick(1'b0, 1'b0);

        checks++;
        if (exp_q.size() != 0 || valids_seen != pushes) begin
            fails++;
            $display("FAIL R6 strobe count actual=%0d expected=%0d",
                     valids_seen, pushes);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule